// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block produces the external memory cycles of a small 8-bit controller whose low address byte and data share a single port. It runs at the oscillator rate, and each strobe edge falls on a whole number of oscillator periods counted from the start of the cycle. The core asks for a code fetch, a data read or a data write, and gives a 16-bit address and, for a write, a data byte. The block answers with the byte read and a one-clock completion pulse.

On the bus side, an address-latch strobe lets an external latch capture the low address byte from the shared port. The high address byte sits on its own port. Code fetches use a program-store strobe. Data accesses use separate read and write strobes. All three are active low. The shared port carries an output enable, so the pad logic can release it while the external memory drives data back.

Clock numbers below count from k=0, the first clock after the edge that accepts a request. The last clock of a fetch is k=6, and the last clock of a read or write is k=11. Op codes on `req_op`: 2'b00 fetch, 2'b01 read, 2'b10 write, 2'b11 reserved.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, and in any clock with no cycle in progress, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0 and `done`=0.
- R2: `ale` is high in clocks k=0 and k=1 of every cycle, and low in all other clocks.
- R3: The low address byte is on `ad_out` with `ad_oe`=1 in clocks k=1 and k=2. `addr_hi` holds `req_addr[15:8]` for the whole cycle, and changes value only in a clock where `ale` is high.
- R4: On a fetch, `psen_n` is low in exactly clocks k=3..5, and `rd_n` and `wr_n` stay high.
- R5: On a read, `rd_n` is low in exactly clocks k=5..10. On a write, `wr_n` is low in exactly clocks k=5..10. `psen_n` stays high in both cases.
- R6: On a write, the write byte is on `ad_out` with `ad_oe`=1 in clocks k=4..11. This starts one clock before `wr_n` falls and ends one clock after it rises.
- R7: On a fetch or a read, `ad_oe`=0 from k=3 onward, so the port is never driven while `psen_n` or `rd_n` is low. `ad_in` is captured at the end of the last strobe-low clock (k=5 for a fetch, k=10 for a read). The captured byte appears on `rdata` from the done clock and is held there.
- R8: `done` is high for exactly one clock, the last clock of the cycle. A request presented in that clock is accepted, so `ale` rises in the next clock, one clock after the data strobe went high.
- R9: A request that arrives while a cycle is in progress, outside the done clock, is ignored. A request with op 2'b11 is ignored. Neither one starts a cycle, and neither one alters `addr_hi`.
- R10: At most one of `psen_n`, `rd_n` and `wr_n` is low in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request a bus cycle |
| req_op | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte captured on the last fetch or read |
| done | output | 1 | One-clock pulse in the final clock of a cycle |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared address/data port, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared port |
| ad_in | input | 8 | Shared address/data port, incoming value |

## Verification
The completion pulse of one cycle and the acceptance of the next request can fall in the same clock. This is the case that keeps the address-latch strobe exactly one period behind the rising data strobe.

The bench provokes it by walking a vector table in which many entries carry no idle gap. Each such entry presents its request in the done clock of the cycle before it.

Each chained cycle is judged clock by clock against the windows in the requirements. The check confirms that the previous byte is still on `rdata` in the done clock, and that `ale` is high in the very next clock. Requests poked into the middle of a cycle, and reserved ops, confirm that only the done clock opens this early acceptance.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);

  localparam int ALE_W      = 2;
  localparam int PSEN_START = ALE_W + 1;
  localparam int PSEN_W     = 3;
  localparam int DS_START   = ALE_W + 3;
  localparam int DS_W       = 6;
  localparam int FETCH_END  = PSEN_START + PSEN_W;
  localparam int DATA_END   = DS_START + DS_W;
  localparam int CW         = $clog2(DATA_END + 1);

  localparam logic [CW-1:0] K_ALE_LAST = CW'(ALE_W - 1);
  localparam logic [CW-1:0] K_ADR_LAST = CW'(ALE_W);
  localparam logic [CW-1:0] K_PS_FIRST = CW'(PSEN_START);
  localparam logic [CW-1:0] K_PS_LAST  = CW'(PSEN_START + PSEN_W - 1);
  localparam logic [CW-1:0] K_DS_FIRST = CW'(DS_START);
  localparam logic [CW-1:0] K_DS_LAST  = CW'(DS_START + DS_W - 1);
  localparam logic [CW-1:0] K_WD_FIRST = CW'(DS_START - 1);
  localparam logic [CW-1:0] K_F_END    = CW'(FETCH_END);
  localparam logic [CW-1:0] K_D_END    = CW'(DATA_END);

  localparam logic [1:0] OP_FETCH = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_RSVD  = 2'b11;

  logic          busy;
  logic [1:0]    op;
  logic [CW-1:0] cnt;
  logic [DW-1:0] lo_q, wd_q;
  logic          accept, adr_ph, wd_ph, ps_ph, ds_ph;
  logic [CW-1:0] last_k, cap_k;

  wire is_fetch = (op == OP_FETCH);
  wire is_read  = (op == OP_READ);
  wire is_write = (op == OP_WRITE);

  assign last_k = is_fetch ? K_F_END : K_D_END;
  assign cap_k  = is_fetch ? K_PS_LAST : K_DS_LAST;
  assign done   = busy && (cnt == last_k);
  assign accept = req && (req_op != OP_RSVD) && (!busy || done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op      <= OP_FETCH;
      cnt     <= '0;
      lo_q    <= '0;
      wd_q    <= '0;
      addr_hi <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      op      <= req_op;
      cnt     <= '0;
      lo_q    <= req_addr[DW-1:0];
      wd_q    <= req_wdata;
      addr_hi <= req_addr[AW-1:DW];
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (busy && !is_write && (cnt == cap_k))
      rdata <= ad_in;
  end

  assign ale    = busy && (cnt <= K_ALE_LAST);
  assign adr_ph = busy && (cnt >= K_ALE_LAST) && (cnt <= K_ADR_LAST);
  assign wd_ph  = busy && is_write && (cnt >= K_WD_FIRST) && (cnt <= K_D_END);
  assign ps_ph  = busy && is_fetch && (cnt >= K_PS_FIRST) && (cnt <= K_PS_LAST);
  assign ds_ph  = busy && (cnt >= K_DS_FIRST) && (cnt <= K_DS_LAST);

  assign psen_n = !ps_ph;
  assign rd_n   = !(ds_ph && is_read);
  assign wr_n   = !(ds_ph && is_write);
  assign ad_oe  = adr_ph || wd_ph;
  assign ad_out = adr_ph ? lo_q : (wd_ph ? wd_q : '0);

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe);

  p_ale_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);

  p_hi_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_hi) |-> ale);

  p_psen_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

  p_wr_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ad_oe));

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> (!ale && psen_n && rd_n && wr_n && !ad_oe));

endmodule

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;
  localparam int CLK_P = 10;
  localparam int NV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic [7:0] rdata, addr_hi, ad_out;
  logic done, ale, psen_n, rd_n, wr_n, ad_oe;

  int checks = 0, errors = 0;
  bit finished = 0;

  // {gap, op, addr, wdata, din, poke}
  localparam logic [38:0] VEC [NV] = '{
    {4'd2, 2'd0, 16'h1234, 8'h00, 8'hA5, 1'b0},
    {4'd0, 2'd1, 16'h8001, 8'h00, 8'h3C, 1'b0},
    {4'd0, 2'd2, 16'hFF00, 8'h5A, 8'h00, 1'b0},
    {4'd3, 2'd2, 16'h00FF, 8'hC3, 8'h11, 1'b1},
    {4'd0, 2'd0, 16'hABCD, 8'h00, 8'h7E, 1'b1},
    {4'd1, 2'd1, 16'h0000, 8'h00, 8'hFF, 1'b0},
    {4'd0, 2'd1, 16'hFFFF, 8'h00, 8'h00, 1'b0},
    {4'd0, 2'd0, 16'h4321, 8'h00, 8'h99, 1'b0}
  };

  mux_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdata(rdata), .done(done), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet(input string tag);
    chk({tag, " ale"}, 16'(ale), 16'd0);
    chk({tag, " strobes"}, 16'({psen_n, rd_n, wr_n}), 16'b111);
    chk({tag, " ad_oe"}, 16'(ad_oe), 16'd0);
    chk({tag, " done"}, 16'(done), 16'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      quiet("R1 idle");
    end
  endtask

  // Entered at a negedge; returns at the negedge of the done clock.
  task automatic run(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd,
                     input logic [7:0] din, input logic poke);
    int last, cap;
    logic f, r, w, eoe;
    f = (op == 2'd0); r = (op == 2'd1); w = (op == 2'd2);
    last = f ? 6 : 11;
    cap  = f ? 5 : 10;
    req = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    for (int k = 0; k <= last; k++) begin
      ad_in = (k == cap) ? din : ~din;
      if (poke && k == 3) begin req = 1'b1; req_op = 2'd1; req_addr = 16'hEEEE; end
      if (poke && k == 4) req = 1'b0;
      chk("R2 ale", 16'(ale), 16'(k < 2));
      chk("R3 addr_hi", 16'(addr_hi), 16'(a[15:8]));
      chk("R4 psen_n", 16'(psen_n), 16'(!(f && k >= 3 && k <= 5)));
      chk("R5 rd_n", 16'(rd_n), 16'(!(r && k >= 5 && k <= 10)));
      chk("R5 wr_n", 16'(wr_n), 16'(!(w && k >= 5 && k <= 10)));
      eoe = (k == 1 || k == 2) || (w && k >= 4 && k <= 11);
      chk(w ? "R6 ad_oe" : "R7 ad_oe", 16'(ad_oe), 16'(eoe));
      if (k == 1 || k == 2) chk("R3 ad_out", 16'(ad_out), 16'(a[7:0]));
      else if (eoe) chk("R6 ad_out", 16'(ad_out), 16'(wd));
      chk("R8 done", 16'(done), 16'(k == last));
      chk("R10 strobes", 16'(int'(!psen_n) + int'(!rd_n) + int'(!wr_n) <= 1), 16'd1);
      if (k == last && !w) chk("R7 rdata", 16'(rdata), 16'(din));
      if (k < last) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    quiet("R1 reset");
    chk("R1 rdata reset", 16'(rdata), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    quiet("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      idle(int'(VEC[i][38:35]));
      run(VEC[i][34:33], VEC[i][32:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
    end
    idle(2);
    chk("R9 addr_hi after pokes", 16'(addr_hi), 16'h0043);

    // R9: reserved op starts nothing.
    req = 1'b1; req_op = 2'b11; req_addr = 16'h5555;
    idle(4);
    chk("R9 rsvd addr_hi", 16'(addr_hi), 16'h0043);
    req = 1'b0;

    // R8: chained write after read; rdata from the read must stay through the write.
    run(2'd1, 16'h2468, 8'h00, 8'h6B, 1'b0);
    run(2'd2, 16'h1357, 8'hE1, 8'h00, 1'b0);
    chk("R8 rdata held", 16'(rdata), 16'h006B);
    idle(1);

    // R1: reset in the middle of a cycle.
    req = 1'b1; req_op = 2'd0; req_addr = 16'h0F0F;
    @(posedge clk); @(negedge clk); req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    quiet("R1 mid reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule